// File: doc/BRIEF.md
# PHY Link-Change Interrupt Registers

This block keeps the interrupt enable and interrupt flag registers of a network PHY. Software reaches both 16-bit registers through a plain register port: an address, a write strobe, a read strobe and separate write and read data buses. The block watches an already synchronized link-status input. Any change of that input, upward or downward, latches a sticky link-change flag. When the link-change enable is also set, the same event latches a global flag. The interrupt request output is the global flag gated by the global enable.

Each sticky flag is a two-state machine. The states are `FLAG_IDLE` (flag reads 0) and `FLAG_PEND` (flag reads 1). `IDLE -> PEND` is taken on a set event. `PEND -> IDLE` is taken on a read of the flag register in a cycle with no set event. `PEND -> PEND` is taken when a set event meets a read, so the set wins. `IDLE -> IDLE` is taken otherwise. Reading the flag register returns the values held before the clear, and it clears both flags together. Writes cannot clear the flags. The enable register sits at address `ADDR_EN` (default 0). The flag register sits at address `ADDR_FLAG` (default 1).

Top module: `phy_link_irq_regs`

## Requirements
- R1: A synchronous active-high reset clears both registers and drops `irq`. The level of `link_up` held through reset is taken as the reference, so no flag sets after release while the link stays at that level.
- R2: A write at `ADDR_EN` stores bit 4 (link-change enable) and bit 1 (global enable). All other enable bits ignore writes and read back as 0.
- R3: A change of `link_up` in either direction sets bit 4 (link-change flag) of the flag register at the next rising clock edge.
- R4: Bit 2 (global flag) of the flag register sets at the same edge as bit 4, and only if enable bit 4 was 1 in the cycle the change was seen.
- R5: With `rd_en` high at `ADDR_FLAG`, `rdata` shows the flags as they were before the clear. Both flags read 0 after that clock edge.
- R6: A link change seen in the same cycle as a flag-register read leaves the link-change flag set. The global flag also stays set if the link-change enable is 1.
- R7: A write at `ADDR_FLAG` has no effect on the flags.
- R8: Flag-register bits other than 4 and 2 always read 0.
- R9: `irq` is 1 exactly when the global flag is 1 and enable bit 1 is 1.
- R10: A read at any other address returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W (4) | Register address |
| wr_en | input | 1 | Write strobe, acts at the clock edge |
| rd_en | input | 1 | Read strobe; clears the flags at a flag-register read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` and register state |
| link_up | input | 1 | Synchronized link status |
| irq | output | 1 | Interrupt request |

## Verification
`rdata` depends combinationally on `addr`, so a read value is due in the same cycle the address is applied. Register updates from writes, link changes and read clears appear one edge later. A link change applied in cycle N shows in the flag bits and on `irq` in cycle N+1. The bench drives every input on the falling edge and samples 1 ns later. Its reference model advances its state only after that sample, so every comparison sees the state left by the edge just passed. The model is compared against `rdata` and `irq` on every cycle.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
    localparam int REG_W        = 16;
    localparam int BIT_LNK      = 4;   // link-change enable / flag position
    localparam int BIT_GLOB_EN  = 1;   // global enable position
    localparam int BIT_GLOB_FLG = 2;   // global flag position

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;
endpackage

// File: rtl/link_edge_det.sv
module link_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic link_in,
    output logic change
);
    logic link_q;

    // reset copies the live level so startup does not look like a change
    always_ff @(posedge clk) begin
        link_q <= link_in;
    end

    assign change = (link_in != link_q) && !rst;
endmodule

// File: rtl/irq_flag_fsm.sv
module irq_flag_fsm
    import phy_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_rd,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_evt) state_d = FLAG_PEND;
            FLAG_PEND: if (clr_rd && !set_evt) state_d = FLAG_IDLE;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_PEND);
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int                W    = 16,
    parameter logic [W-1:0]      MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata & MASK;
    end
endmodule

// File: rtl/phy_link_irq_regs.sv
module phy_link_irq_regs
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ADDR_EN   = 0,
    parameter int ADDR_FLAG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              link_up,
    output logic              irq
);
    localparam int NFLAG = 2;
    localparam logic [REG_W-1:0] EN_MASK =
        (REG_W'(1) << BIT_LNK) | (REG_W'(1) << BIT_GLOB_EN);

    logic               sel_en, sel_flag;
    logic               wr_flag, flag_rd;
    logic               link_evt;
    logic [REG_W-1:0]   en_reg;
    logic               en_lnk, en_glob;
    logic [NFLAG-1:0]   set_vec, flag_vec;
    logic               lnk_flag, glob_flag;
    logic [REG_W-1:0]   flag_word;

    assign sel_en   = (addr == ADDR_W'(ADDR_EN));
    assign sel_flag = (addr == ADDR_W'(ADDR_FLAG));
    assign wr_flag  = wr_en && sel_flag;
    assign flag_rd  = rd_en && sel_flag;

    link_edge_det u_det (
        .clk     (clk),
        .rst     (rst),
        .link_in (link_up),
        .change  (link_evt)
    );

    irq_enable_reg #(.W(REG_W), .MASK(EN_MASK)) u_en (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && sel_en),
        .wdata (wdata),
        .q     (en_reg)
    );

    assign en_lnk  = en_reg[BIT_LNK];
    assign en_glob = en_reg[BIT_GLOB_EN];

    // index 0: link-change flag, index 1: global flag
    assign set_vec = {link_evt && en_lnk, link_evt};

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        irq_flag_fsm u_fsm (
            .clk     (clk),
            .rst     (rst),
            .set_evt (set_vec[i]),
            .clr_rd  (flag_rd),
            .flag    (flag_vec[i])
        );
    end

    assign lnk_flag  = flag_vec[0];
    assign glob_flag = flag_vec[1];

    always_comb begin
        flag_word               = '0;
        flag_word[BIT_LNK]      = lnk_flag;
        flag_word[BIT_GLOB_FLG] = glob_flag;
    end

    always_comb begin
        if (sel_en)        rdata = en_reg;
        else if (sel_flag) rdata = flag_word;
        else               rdata = '0;
    end

    assign irq = glob_flag && en_glob;
endmodule

// File: rtl/phy_link_irq_chk.sv
module phy_link_irq_chk (
    input logic clk,
    input logic rst,
    input logic link_evt,
    input logic flag_rd,
    input logic wr_flag,
    input logic en_lnk,
    input logic lnk_flag,
    input logic glob_flag
);
    AST_EVENT_SETS_LINK_FLAG: assert property (@(posedge clk) disable iff (rst)
        link_evt |=> lnk_flag); // R3

    AST_GLOBAL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(glob_flag) |-> $past(link_evt && en_lnk)); // R4

    AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && !link_evt) |=> (!lnk_flag && !glob_flag)); // R5

    AST_EVENT_BEATS_READ: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && link_evt) |=> lnk_flag); // R6

    AST_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_flag && !flag_rd && !link_evt) |=> $stable(lnk_flag)); // R7
endmodule

bind phy_link_irq_regs phy_link_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .link_evt  (link_evt),
    .flag_rd   (flag_rd),
    .wr_flag   (wr_flag),
    .en_lnk    (en_lnk),
    .lnk_flag  (lnk_flag),
    .glob_flag (glob_flag)
);

// File: tb/phy_link_irq_regs_test.sv
`timescale 1ns/100ps
module phy_link_irq_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        link_up = 1'b1;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_en;
    bit          m_lf, m_gf, m_prev;

    always #2.5 clk = ~clk;

    phy_link_irq_regs uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .link_up(link_up), .irq(irq)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic l);
        @(negedge clk);
        rst = 1'b1; wr_en = 0; rd_en = 0; link_up = l;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_en = '0; m_lf = 0; m_gf = 0; m_prev = l;
    endtask

    // one cycle: drive, sample, then advance the model past the next edge
    task automatic step(input string tag, input logic [3:0] a, input logic w,
                        input logic r, input logic [15:0] d, input logic l);
        logic [15:0] exp_rd;
        bit ev, clr;
        @(negedge clk);
        addr = a; wr_en = w; rd_en = r; wdata = d; link_up = l;
        #1;
        if (a == 4'd0)      exp_rd = m_en;
        else if (a == 4'd1) exp_rd = (16'(m_lf) << 4) | (16'(m_gf) << 2);
        else                exp_rd = '0;
        check(tag, "rdata", rdata, exp_rd);
        check(tag, "irq", {15'b0, irq}, {15'b0, m_gf && m_en[1]});
        ev  = (l != m_prev);
        clr = r && (a == 4'd1);
        m_gf = (ev && m_en[4]) || (m_gf && !clr);
        m_lf = ev || (m_lf && !clr);
        if (w && a == 4'd0) m_en = d & 16'h0012;
        m_prev = l;
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        // R1: reset state, no spurious event with link held high
        step("R1", 4'd1, 0, 0, 16'h0, 1);
        step("R1", 4'd0, 0, 0, 16'h0, 1);
        step("R1", 4'd1, 0, 1, 16'h0, 1);
        // R2: enable register masking
        step("R2", 4'd0, 1, 0, 16'hFFFF, 1);
        step("R2", 4'd0, 0, 0, 16'h0, 1);
        step("R2", 4'd0, 1, 0, 16'hFFED, 1);
        step("R2", 4'd0, 0, 0, 16'h0, 1);
        step("R2", 4'd0, 1, 0, 16'h0012, 1);
        // R3 falling change, R4 global set, R9 irq
        step("R3", 4'd1, 0, 0, 16'h0, 0);
        step("R9", 4'd1, 0, 0, 16'h0, 0);
        step("R8", 4'd1, 0, 0, 16'h0, 0);
        // R5: read returns pre-clear values, then zero
        step("R5", 4'd1, 0, 1, 16'h0, 0);
        step("R5", 4'd1, 0, 0, 16'h0, 0);
        // R3 rising change; R7 write to flags has no effect
        step("R3", 4'd1, 0, 0, 16'h0, 1);
        step("R7", 4'd1, 1, 0, 16'h0000, 1);
        step("R7", 4'd1, 1, 0, 16'hFFFF, 1);
        step("R7", 4'd1, 0, 0, 16'h0, 1);
        step("R5", 4'd1, 0, 1, 16'h0, 1);
        step("R7", 4'd1, 1, 0, 16'hFFFF, 1);
        step("R7", 4'd1, 0, 0, 16'h0, 1);
        // R9: global enable off, flag set, irq low
        step("R9", 4'd0, 1, 0, 16'h0010, 1);
        step("R9", 4'd1, 0, 0, 16'h0, 0);
        step("R9", 4'd1, 0, 0, 16'h0, 0);
        step("R9", 4'd0, 1, 0, 16'h0012, 0);
        step("R9", 4'd1, 0, 1, 16'h0, 0);
        // R4: link enable off, only bit 4 sets
        step("R4", 4'd0, 1, 0, 16'h0002, 0);
        step("R4", 4'd1, 0, 0, 16'h0, 1);
        step("R4", 4'd1, 0, 1, 16'h0, 1);
        step("R4", 4'd1, 0, 0, 16'h0, 1);
        // R6: change in the same cycle as a read
        step("R6", 4'd0, 1, 0, 16'h0012, 1);
        step("R6", 4'd1, 0, 1, 16'h0, 0);
        step("R6", 4'd1, 0, 0, 16'h0, 0);
        step("R6", 4'd1, 0, 1, 16'h0, 1);
        step("R6", 4'd1, 0, 1, 16'h0, 1);
        step("R6", 4'd1, 0, 0, 16'h0, 1);
        // R10: other addresses read 0 and leave state alone
        step("R10", 4'd1, 0, 0, 16'h0, 0);
        step("R10", 4'd7, 1, 1, 16'hFFFF, 0);
        step("R10", 4'd15, 0, 1, 16'h0, 0);
        step("R10", 4'd1, 0, 0, 16'h0, 0);
        step("R10", 4'd0, 0, 0, 16'h0, 0);
        // R1: reset with flags pending and link low
        do_reset(1'b0);
        step("R1", 4'd1, 0, 0, 16'h0, 0);
        step("R1", 4'd0, 0, 0, 16'h0, 0);
        step("R1", 4'd1, 0, 0, 16'h0, 0);
        // short alternating burst
        step("R2", 4'd0, 1, 0, 16'h0012, 0);
        for (int i = 0; i < 6; i++) step("R3", 4'd1, 0, (i % 3) == 2, 16'h0, i[0]);
        step("R5", 4'd1, 0, 1, 16'h0, 1);
        step("R5", 4'd1, 0, 0, 16'h0, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule